// File: doc/BRIEF.md
# Asynchronous Processor Bus to Register Bus Bridge

This block lets an external processor with an asynchronous, strobe-based bus reach an internal clocked register bus. The processor presents an address, a read/write select and, for writes, data. It then pulls its select, address strobe and data strobe low and waits for the bridge to answer on a tri-stateable acknowledge line. The bridge passes the strobes through synchronizers and issues exactly one request on the internal ready/valid style register bus. When the internal side reports completion, the bridge pulls acknowledge low. On a read it also drives the returned data onto the shared data bus.

The acknowledge pad has three conditions. It is driven high while the internal access is outstanding and driven low once the access completes. When the processor lets a strobe go, it is driven high for one clock and then released. Read data stays on the bus until the address strobe rises, so a processor that keeps the address strobe low after the data strobe has ended still sees stable data. The pads are modelled as separate data-out and output-enable signals.

Top module: `cpu_bus_bridge`

## Requirements
- R1: During and straight after reset, the acknowledge enable, the data enable and the internal request are all low.
- R2: Select, address strobe and data strobe are active low. An internal request begins only after all three have been seen low through the synchronizers. With select high, strobe activity starts nothing.
- R3: The request carries the address and write data presented with the strobes. `int_we` is 1 when the read/write select is low (write) and 0 when it is high (read). The request is held until `int_ready` is 1.
- R4: From the start of the request until the internal side completes, acknowledge is enabled and high. After completion it is enabled and low.
- R5: When the address strobe or data strobe rises with select still low, acknowledge is driven high for exactly one clock and then its enable drops.
- R6: While the synchronized select is high, the acknowledge enable is low. This holds both when idle and when select rises after completion.
- R7: On a read, once acknowledge is low, the data enable is high and the data bus carries `int_rdata` from the completing clock. The data stays stable until the address strobe is seen high, and the enable then drops.
- R8: Each external cycle produces exactly one internal request, even when all strobes stay low long after completion.
- R9: No new cycle starts until select, address strobe and data strobe have all been seen high since the previous one.
- R10: A write cycle never enables the data bus output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Processor address |
| bus_data_in | input | 16 | Data bus as seen at the pad (write data) |
| bus_data_out | output | 16 | Read data to the pad |
| bus_data_oe | output | 1 | Data pad output enable |
| bus_rd_wr | input | 1 | 1 = read, 0 = write |
| bus_sel_n | input | 1 | Chip select, active low |
| bus_astb_n | input | 1 | Address strobe, active low |
| bus_dstb_n | input | 1 | Data strobe, active low |
| bus_ack_out | output | 1 | Acknowledge level (low = transfer done) |
| bus_ack_oe | output | 1 | Acknowledge pad output enable |
| int_req | output | 1 | Internal request valid |
| int_we | output | 1 | Internal write enable |
| int_addr | output | 16 | Internal address |
| int_wdata | output | 16 | Internal write data |
| int_ready | input | 1 | Internal completion |
| int_rdata | input | 16 | Internal read data |

## Verification
The bench sweeps reads and writes over several addresses and every internal completion latency from zero to three clocks. Each case is run both with the address strobe released together with the data strobe and with it held low afterwards. A bridge that keyed read-data release to the data strobe would drop the bus too early in the held case. A bridge that re-triggered on level would issue a second request while the strobes linger low. The bench also checks four further cases. Select high with strobes low must start nothing. Select rising before the strobes must float acknowledge at once instead of driving it. The data strobe bouncing while the address strobe stays low must not re-arm the bridge. Acknowledge must be driven high for exactly one clock before release, so a bridge that floated it straight away or held it driven would be caught.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;

    localparam int BUS_ADDR_W  = 16;
    localparam int BUS_DATA_W  = 16;
    localparam int SYNC_DEPTH  = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_DONE,
        ST_RELEASE,
        ST_REARM
    } cyc_state_t;

    // synchronized strobe levels, active low as on the pins
    typedef struct packed {
        logic sel;
        logic adr;
        logic dat;
    } strobe_t;

    function automatic logic strobes_all_low(strobe_t s);
        return !s.sel && !s.adr && !s.dat;
    endfunction

    function automatic logic strobes_all_high(strobe_t s);
        return s.sel && s.adr && s.dat;
    endfunction

    function automatic logic strobes_any_high(strobe_t s);
        return s.sel || s.adr || s.dat;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    localparam int LAST = STAGES - 1;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_line
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain <= '1;
                end else begin
                    chain <= {chain[STAGES-2:0], async_in[i]};
                end
            end
            assign sync_out[i] = chain[LAST];
        end
    endgenerate
endmodule

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
    import cpu_bus_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t lines,
    input  logic    int_ready,
    output logic    int_req,
    output logic    start_pulse,
    output logic    done_pulse,
    output logic    ack_out,
    output logic    ack_oe
);
    cyc_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (strobes_all_low(lines))  state_nx = ST_PEND;
            ST_PEND:    if (int_ready)               state_nx = ST_DONE;
            ST_DONE:    if (strobes_any_high(lines)) state_nx = ST_RELEASE;
            ST_RELEASE:                              state_nx = ST_REARM;
            ST_REARM:   if (strobes_all_high(lines)) state_nx = ST_IDLE;
            default:                                 state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    assign int_req     = (state == ST_PEND);
    assign start_pulse = (state == ST_IDLE) && strobes_all_low(lines);
    assign done_pulse  = (state == ST_PEND) && int_ready;
    assign ack_out     = (state != ST_DONE);
    assign ack_oe      = (state inside {ST_PEND, ST_DONE, ST_RELEASE}) && !lines.sel;

    AST_START_ALL_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(int_req) |-> $past(strobes_all_low(lines)));            // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        int_req && !int_ready |=> int_req);                            // R3
    AST_ACK_LOW_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
        ack_oe && !ack_out |-> !int_req);                              // R4
    AST_ACK_HIGH_BEFORE_FLOAT: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_oe) && !lines.sel |-> $past(ack_out));               // R5
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (rst)
        int_req && int_ready |=> !int_req);                            // R8
endmodule

// File: rtl/data_path.sv
module data_path #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_pulse,
    input  logic              done_pulse,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd_wr,
    input  logic              adr_sync_n,
    input  logic [DATA_W-1:0] int_rdata,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    output logic              int_we,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe
);
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              we_q;
    logic              rd_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else if (start_pulse) begin
            addr_q  <= bus_addr;
            wdata_q <= bus_wdata;
            we_q    <= !bus_rd_wr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            rd_hold <= 1'b0;
        end else if (done_pulse && !we_q) begin
            rdata_q <= int_rdata;
            rd_hold <= 1'b1;
        end else if (adr_sync_n) begin
            rd_hold <= 1'b0;
        end
    end

    assign int_addr  = addr_q;
    assign int_wdata = wdata_q;
    assign int_we    = we_q;
    assign data_out  = rdata_q;
    assign data_oe   = rd_hold && !adr_sync_n;

    AST_RDATA_STABLE: assert property (@(posedge clk) disable iff (rst)
        data_oe && $past(data_oe) |-> $stable(data_out));              // R7
    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> !int_we);                                          // R10
endmodule

// File: rtl/cpu_bus_bridge.sv
module cpu_bus_bridge
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W      = BUS_ADDR_W,
    parameter int DATA_W      = BUS_DATA_W,
    parameter int SYNC_STAGES = SYNC_DEPTH
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data_in,
    output logic [DATA_W-1:0] bus_data_out,
    output logic              bus_data_oe,
    input  logic              bus_rd_wr,
    input  logic              bus_sel_n,
    input  logic              bus_astb_n,
    input  logic              bus_dstb_n,
    output logic              bus_ack_out,
    output logic              bus_ack_oe,
    output logic              int_req,
    output logic              int_we,
    output logic [ADDR_W-1:0] int_addr,
    output logic [DATA_W-1:0] int_wdata,
    input  logic              int_ready,
    input  logic [DATA_W-1:0] int_rdata
);
    localparam int N_STROBES = $bits(strobe_t);

    logic [N_STROBES-1:0] raw_lines;
    strobe_t              lines_s;
    logic                 start_pulse;
    logic                 done_pulse;

    assign raw_lines = {bus_sel_n, bus_astb_n, bus_dstb_n};

    strobe_sync #(
        .WIDTH (N_STROBES),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(raw_lines),
        .sync_out(lines_s)
    );

    cycle_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .lines      (lines_s),
        .int_ready  (int_ready),
        .int_req    (int_req),
        .start_pulse(start_pulse),
        .done_pulse (done_pulse),
        .ack_out    (bus_ack_out),
        .ack_oe     (bus_ack_oe)
    );

    data_path #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_data (
        .clk        (clk),
        .rst        (rst),
        .start_pulse(start_pulse),
        .done_pulse (done_pulse),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_data_in),
        .bus_rd_wr  (bus_rd_wr),
        .adr_sync_n (lines_s.adr),
        .int_rdata  (int_rdata),
        .int_addr   (int_addr),
        .int_wdata  (int_wdata),
        .int_we     (int_we),
        .data_out   (bus_data_out),
        .data_oe    (bus_data_oe)
    );

    AST_SEL_HIGH_FLOATS: assert property (@(posedge clk) disable iff (rst)
        $past(bus_sel_n) && bus_sel_n && $past(bus_sel_n, 2) |=> !bus_ack_oe); // R6
endmodule

// File: tb/cpu_bus_bridge_tb.sv
module cpu_bus_bridge_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] bus_addr, bus_data_in, bus_data_out;
    logic        bus_data_oe, bus_rd_wr, bus_sel_n, bus_astb_n, bus_dstb_n;
    logic        bus_ack_out, bus_ack_oe;
    logic        int_req, int_we, int_ready;
    logic [15:0] int_addr, int_wdata, int_rdata;

    int errors = 0;
    int checks = 0;
    int hs_count = 0;
    int lat_cfg = 0;
    int lat_cnt = 0;
    logic [15:0] rec_addr, rec_wdata;
    logic        rec_we;
    bit          finished = 0;

    always #10 clk = ~clk;  // 50 MHz

    cpu_bus_bridge dut_i (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_data_in(bus_data_in),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe),
        .bus_rd_wr(bus_rd_wr), .bus_sel_n(bus_sel_n),
        .bus_astb_n(bus_astb_n), .bus_dstb_n(bus_dstb_n),
        .bus_ack_out(bus_ack_out), .bus_ack_oe(bus_ack_oe),
        .int_req(int_req), .int_we(int_we), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_ready(int_ready), .int_rdata(int_rdata)
    );

    assign int_rdata = int_addr ^ 16'hA5C3;

    // internal responder: completes after lat_cfg extra clocks
    initial int_ready = 1'b0;
    always @(negedge clk) begin
        if (int_ready) begin
            int_ready = 1'b0;
            lat_cnt   = 0;
        end else if (int_req) begin
            if (lat_cnt == lat_cfg) begin
                int_ready = 1'b1;
                hs_count  = hs_count + 1;
                rec_addr  = int_addr;
                rec_wdata = int_wdata;
                rec_we    = int_we;
            end else begin
                lat_cnt = lat_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_sel_n = 1'b1; bus_astb_n = 1'b1; bus_dstb_n = 1'b1;
    endtask

    task automatic bus_cycle(input logic [15:0] addr, input logic [15:0] wd,
                             input bit rd, input int lat, input bit hold_as);
        int  hs0;
        bit  saw_pend = 0;
        bit  got_done = 0;
        logic [15:0] exp_rd;
        exp_rd  = addr ^ 16'hA5C3;
        lat_cfg = lat;
        hs0     = hs_count;
        @(negedge clk);
        bus_addr = addr; bus_data_in = wd; bus_rd_wr = rd;
        bus_sel_n = 1'b0; bus_astb_n = 1'b0; bus_dstb_n = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (bus_ack_oe && bus_ack_out) saw_pend = 1;
            if (bus_ack_oe && !bus_ack_out) begin got_done = 1; break; end
        end
        chk(saw_pend, "R4 ack high while pending", 0, 1);
        chk(got_done, "R4 ack low on completion", 0, 1);
        chk(hs_count == hs0 + 1, "R3 one request issued", hs_count - hs0, 1);
        chk(rec_addr == addr, "R3 address", rec_addr, addr);
        chk(rec_we == !rd, "R3 write enable", rec_we, !rd);
        if (!rd) chk(rec_wdata == wd, "R3 write data", rec_wdata, wd);
        if (rd) begin
            chk(bus_data_oe == 1'b1, "R7 read data enabled", bus_data_oe, 1);
            chk(bus_data_out == exp_rd, "R7 read data value", bus_data_out, exp_rd);
        end else begin
            chk(bus_data_oe == 1'b0, "R10 write leaves data bus", bus_data_oe, 0);
        end
        repeat (6) @(negedge clk);
        chk(hs_count == hs0 + 1, "R8 no repeat request", hs_count - hs0, 1);
        chk(bus_ack_oe && !bus_ack_out, "R8 ack stays low", {bus_ack_oe, bus_ack_out}, 2);
        bus_dstb_n = 1'b1;
        if (!hold_as) bus_astb_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_ack_out) break;
        end
        chk(bus_ack_oe && bus_ack_out, "R5 ack driven high", {bus_ack_oe, bus_ack_out}, 3);
        @(negedge clk);
        chk(!bus_ack_oe, "R5 ack released next clock", bus_ack_oe, 0);
        if (hold_as && rd) begin
            chk(bus_data_oe && bus_data_out == exp_rd, "R7 data held while AS low",
                bus_data_out, exp_rd);
            bus_astb_n = 1'b1;
            repeat (4) @(negedge clk);
            chk(!bus_data_oe, "R7 data released after AS high", bus_data_oe, 0);
        end
        if (rd) chk(!bus_data_oe, "R7 data released", bus_data_oe, 0);
        idle_bus();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [15:0] addrs [3];
        int hs0;
        addrs[0] = 16'h0000; addrs[1] = 16'h5A3C; addrs[2] = 16'hFFFF;
        rst = 1'b1; bus_addr = '0; bus_data_in = '0; bus_rd_wr = 1'b1;
        idle_bus();
        repeat (3) @(negedge clk);
        chk(!bus_ack_oe && !bus_data_oe && !int_req, "R1 reset outputs",
            {bus_ack_oe, bus_data_oe, int_req}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(!bus_ack_oe && !bus_data_oe && !int_req, "R1 after reset",
            {bus_ack_oe, bus_data_oe, int_req}, 0);

        // R2/R6: strobes low with select high start nothing
        hs0 = hs_count;
        bus_astb_n = 1'b0; bus_dstb_n = 1'b0;
        repeat (10) @(negedge clk);
        chk(hs_count == hs0, "R2 no request with select high", hs_count - hs0, 0);
        chk(!bus_ack_oe, "R6 ack floats with select high", bus_ack_oe, 0);
        idle_bus();
        repeat (4) @(negedge clk);

        // main sweep
        for (int lat = 0; lat < 4; lat++)
            for (int rd = 0; rd < 2; rd++)
                for (int h = 0; h < 2; h++)
                    for (int a = 0; a < 3; a++)
                        bus_cycle(addrs[a] ^ 16'(lat * 16'h1111),
                                  16'h1234 + 16'(a * 16'h0F0F + lat),
                                  rd[0], lat, h[0]);

        // R6: select rises first, ack must float without a drive-high clock
        lat_cfg = 1;
        @(negedge clk);
        bus_addr = 16'h0042; bus_rd_wr = 1'b0;
        bus_sel_n = 1'b0; bus_astb_n = 1'b0; bus_dstb_n = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (bus_ack_oe && !bus_ack_out) break;
        end
        bus_sel_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!bus_ack_oe || bus_ack_out) break;
        end
        chk(!bus_ack_oe, "R6 select high floats ack", bus_ack_oe, 0);
        idle_bus();
        repeat (5) @(negedge clk);

        // R9: data strobe bounces with AS and select still low
        hs0 = hs_count;
        bus_rd_wr = 1'b1; bus_addr = 16'h0777;
        bus_sel_n = 1'b0; bus_astb_n = 1'b0; bus_dstb_n = 1'b0;
        repeat (15) @(negedge clk);
        bus_dstb_n = 1'b1;
        repeat (8) @(negedge clk);
        bus_dstb_n = 1'b0;
        repeat (12) @(negedge clk);
        chk(hs_count == hs0 + 1, "R9 no re-arm without all high", hs_count - hs0, 1);
        chk(!bus_ack_oe, "R9 ack idle while waiting", bus_ack_oe, 0);
        idle_bus();
        repeat (5) @(negedge clk);
        bus_cycle(16'h0778, 16'h0, 1'b1, 0, 1'b0);
        chk(hs_count == hs0 + 2, "R9 cycle after full release", hs_count - hs0, 2);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule